// File: doc/BRIEF.md
# Pixel and Line Dropping Video Down-Scaler

This block shrinks an incoming video field by discarding whole pixels and whole lines, with no filtering. The kept pixel words go into a 16-entry, 32-bit output queue that a memory-side client drains with a read strobe. Horizontally, `cfg_xd` of every `cfg_xs` input pixels on a line are kept, spread evenly along the line. Vertically, `cfg_yd` of every `cfg_ys` lines are kept, but only inside the scaling region.

The field is divided by line index. Lines before `cfg_byp_lines` form a bypass region: every pixel of those lines is kept. Lines from `cfg_scl_start` onward form the scaling region. Lines between the two are discarded. All six configuration inputs are captured into shadow registers on the rising edge of vertical sync, so a change made during a field takes effect only in the next field.

The client sees a show-ahead read port, an empty flag, a half-full flag, a sticky overflow flag, a pulse after each kept line and a pulse at each field start. Before the first vertical sync, all shadow values are zero, so every pixel of every line is kept.

Top module: `pix_drop_scaler`

## Requirements
- R1: On a scaled line, input pixel i (0-based, counting pixels with `in_valid` and `in_href` high) is kept exactly when floor((i+1)·XD/XS) differs from floor(i·XD/XS), where XD < XS.
- R2: In the scaling region, scaled line k (0-based from `cfg_scl_start`) is kept exactly when floor((k+1)·YD/YS) differs from floor(k·YD/YS), where YD < YS. Its pixels then follow R1.
- R3: A line whose index in the field is below the bypass count has all its pixels kept, whatever the XD, XS, YD and YS values.
- R4: A line whose index is at or above the bypass count but below the scaling-region start writes nothing. The bench assumes the start is not below the bypass count.
- R5: When XD ≥ XS, every pixel of a kept scaled line is kept. When YD ≥ YS, every line of the scaling region is kept. XD = 0 with XS > 0 keeps no pixel.
- R6: The configuration inputs take effect only at a rising edge of `in_vsync`. A change made in mid-field leaves the remaining lines of that field unaffected.
- R7: Kept words leave in arrival order. `rd_data` shows the oldest word while `out_empty` is low. `rd_en` removes it at the clock edge. `out_half` is high while 8 or more words are held.
- R8: A kept word that arrives while 16 words are held is discarded and sets `out_ovf`. `out_ovf` stays set until reset, and the stored words are left intact.
- R9: `rd_en` while the queue is empty has no effect: the queue stays empty, and later words are read back correctly.
- R10: `line_inc` is high for one cycle, in the cycle after the clock edge at which `in_href` is first sampled low following a kept line (bypass or vertically kept, even with no kept pixel). It stays low after a discarded line.
- R11: `vreset` is high for one cycle, in the cycle after the clock edge at which a rising `in_vsync` is sampled.
- R12: After reset, `out_empty` is 1 and `out_half`, `out_ovf`, `line_inc` and `vreset` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Pixel present on `in_data` |
| in_href | input | 1 | High during the active part of a line |
| in_vsync | input | 1 | Field start; the rising edge is used |
| in_data | input | 32 | Pixel word |
| cfg_xd | input | 10 | Pixels kept per group |
| cfg_xs | input | 10 | Pixel group size |
| cfg_yd | input | 10 | Lines kept per group |
| cfg_ys | input | 10 | Line group size |
| cfg_byp_lines | input | 10 | Number of bypass lines at field top |
| cfg_scl_start | input | 10 | First line index of the scaling region |
| rd_en | input | 1 | Pop the oldest word |
| rd_data | output | 32 | Oldest held word (show-ahead) |
| out_empty | output | 1 | No word held |
| out_half | output | 1 | 8 or more words held |
| out_ovf | output | 1 | Sticky: a kept word was lost to a full queue |
| line_inc | output | 1 | One-cycle pulse after each kept line |
| vreset | output | 1 | One-cycle pulse at field start |

## Verification
The properties assume that `in_href` drops for at least one cycle between lines and that `in_vsync` rises only while `in_href` is low. They also assume `cfg_scl_start` is not below `cfg_byp_lines`, and that the keep ratios are no larger than the 10-bit counters can hold. The stimulus follows all of these rules. It drains the queue after every line and never places more than 16 kept words in one line, except in the single line meant to force an overflow. Configuration inputs change only between lines, and the mid-field change is made while `in_href` is low.

// File: rtl/scl_pkg.sv
package scl_pkg;
  parameter int CNT_W      = 10;
  parameter int WORD_W     = 32;
  parameter int FIFO_DEPTH = 16;
endpackage

// File: rtl/keep_accum.sv
module keep_accum #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         keep
);
  logic [W:0] acc_q, acc_d, sum;
  logic       all_keep;

  assign all_keep = (num >= den);
  assign sum      = acc_q + {1'b0, num};
  assign keep     = all_keep | (sum >= {1'b0, den});

  always_comb begin
    acc_d = acc_q;
    if (clr)           acc_d = '0;
    else if (step) begin
      if (all_keep)    acc_d = '0;
      else if (keep)   acc_d = sum - {1'b0, den};
      else             acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic         half,
  output logic         ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] CNT_HALF = (AW+1)'(DEPTH / 2);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          wr_ok, rd_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_FULL);
  assign half    = (cnt_q >= CNT_HALF);
  assign ovf     = ovf_q;
  assign rd_data = mem[rp_q];
  assign wr_ok   = wr_req & ~full;
  assign rd_ok   = rd_req & ~empty;

  always_comb begin
    wp_d  = wr_ok ? wp_q + 1'b1 : wp_q;
    rp_d  = rd_ok ? rp_q + 1'b1 : rp_q;
    cnt_d = cnt_q;
    if (wr_ok & ~rd_ok)      cnt_d = cnt_q + 1'b1;
    else if (rd_ok & ~wr_ok) cnt_d = cnt_q - 1'b1;
    ovf_d = ovf_q | (wr_req & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_data;
  end
endmodule

// File: rtl/pix_drop_scaler.sv
module pix_drop_scaler
  import scl_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int DW = WORD_W,
  parameter int QD = FIFO_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_href,
  input  logic          in_vsync,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] cfg_xd,
  input  logic [CW-1:0] cfg_xs,
  input  logic [CW-1:0] cfg_yd,
  input  logic [CW-1:0] cfg_ys,
  input  logic [CW-1:0] cfg_byp_lines,
  input  logic [CW-1:0] cfg_scl_start,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          out_empty,
  output logic          out_half,
  output logic          out_ovf,
  output logic          line_inc,
  output logic          vreset
);
  localparam logic [CW-1:0] LINE_MAX = '1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  logic          vs_q, href_q, vs_rise, href_fall;
  logic [CW-1:0] sh_xd, sh_xs, sh_yd, sh_ys, sh_byp, sh_scl;
  logic [CW-1:0] line_q, line_d;
  logic          in_byp, in_scl, v_keep, h_keep, line_keep, pix_in;
  logic          fifo_wr, fifo_full;
  logic          line_inc_q, line_inc_d, vreset_q, vreset_d;

  assign vs_rise   = in_vsync & ~vs_q;
  assign href_fall = href_q & ~in_href;
  assign in_byp    = (line_q < sh_byp);
  assign in_scl    = (line_q >= sh_scl);
  assign line_keep = in_byp | (in_scl & v_keep);
  assign pix_in    = in_valid & in_href & line_keep;
  assign fifo_wr   = pix_in & (in_byp | h_keep);

  always_comb begin
    line_d = line_q;
    if (vs_rise)                             line_d = '0;
    else if (href_fall && line_q != LINE_MAX) line_d = line_q + 1'b1;
    line_inc_d = href_fall & line_keep;
    vreset_d   = vs_rise;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      vs_q       <= 1'b0;
      href_q     <= 1'b0;
      line_q     <= '0;
      line_inc_q <= 1'b0;
      vreset_q   <= 1'b0;
    end else begin
      vs_q       <= in_vsync;
      href_q     <= in_href;
      line_q     <= line_d;
      line_inc_q <= line_inc_d;
      vreset_q   <= vreset_d;
    end
  end

  // shadow configuration, enabled by field start
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sh_xd  <= '0;
      sh_xs  <= '0;
      sh_yd  <= '0;
      sh_ys  <= '0;
      sh_byp <= '0;
      sh_scl <= '0;
    end else if (vs_rise) begin
      sh_xd  <= cfg_xd;
      sh_xs  <= cfg_xs;
      sh_yd  <= cfg_yd;
      sh_ys  <= cfg_ys;
      sh_byp <= cfg_byp_lines;
      sh_scl <= cfg_scl_start;
    end
  end

  keep_accum #(.W(CW)) u_vacc (
    .clk(clk), .rst_n(rst_i),
    .clr(vs_rise), .step(href_fall & ~in_byp & in_scl),
    .num(sh_yd), .den(sh_ys), .keep(v_keep)
  );

  keep_accum #(.W(CW)) u_hacc (
    .clk(clk), .rst_n(rst_i),
    .clr(~in_href | vs_rise), .step(pix_in & ~in_byp),
    .num(sh_xd), .den(sh_xs), .keep(h_keep)
  );

  word_fifo #(.W(DW), .DEPTH(QD)) u_fifo (
    .clk(clk), .rst_n(rst_i),
    .wr_req(fifo_wr), .wr_data(in_data),
    .rd_req(rd_en), .rd_data(rd_data),
    .empty(out_empty), .full(fifo_full), .half(out_half), .ovf(out_ovf)
  );

  assign line_inc = line_inc_q;
  assign vreset   = vreset_q;
endmodule

// File: rtl/scaler_chk.sv
module scaler_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_en,
  input logic fifo_wr,
  input logic fifo_full,
  input logic out_empty,
  input logic out_half,
  input logic out_ovf,
  input logic line_inc,
  input logic vreset
);
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |=> out_ovf);

  p_drop_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && fifo_wr) |=> out_ovf);

  p_first_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_empty && fifo_wr) |=> !out_empty);

  p_half_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_half |-> !out_empty);

  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_empty && rd_en && !fifo_wr) |=> out_empty);

  p_line_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_inc |=> !line_inc);

  p_field_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vreset |=> !vreset);
endmodule

bind pix_drop_scaler scaler_chk u_scaler_chk (
  .clk(clk), .rst_n(rst_i), .rd_en(rd_en), .fifo_wr(fifo_wr),
  .fifo_full(fifo_full), .out_empty(out_empty), .out_half(out_half),
  .out_ovf(out_ovf), .line_inc(line_inc), .vreset(vreset)
);

// File: tb/test_pix_drop_scaler.sv
`timescale 1ns/1ps
module test_pix_drop_scaler;
  logic        clk = 1'b0;
  logic        rst_n, in_valid, in_href, in_vsync, rd_en;
  logic [31:0] in_data, rd_data;
  logic [9:0]  cfg_xd, cfg_xs, cfg_yd, cfg_ys, cfg_byp_lines, cfg_scl_start;
  logic        out_empty, out_half, out_ovf, line_inc, vreset;

  always #4 clk = ~clk;

  pix_drop_scaler i_pix_drop_scaler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_href(in_href),
    .in_vsync(in_vsync), .in_data(in_data), .cfg_xd(cfg_xd), .cfg_xs(cfg_xs),
    .cfg_yd(cfg_yd), .cfg_ys(cfg_ys), .cfg_byp_lines(cfg_byp_lines),
    .cfg_scl_start(cfg_scl_start), .rd_en(rd_en), .rd_data(rd_data),
    .out_empty(out_empty), .out_half(out_half), .out_ovf(out_ovf),
    .line_inc(line_inc), .vreset(vreset)
  );

  // {xd, xs, yd, ys, byp, scl, pixels per line, lines}
  localparam int VEC [5][8] = '{
    '{4, 4, 3, 3, 0, 0,  6, 3},
    '{2, 3, 1, 2, 0, 0,  9, 4},
    '{3, 7, 2, 5, 1, 2, 10, 6},
    '{5, 3, 1, 1, 2, 3,  8, 4},
    '{0, 5, 1, 3, 1, 1,  5, 3}
  };

  int          checks = 0, fails = 0;
  bit          done = 1'b0;
  logic [31:0] ex_q [0:31];
  int          ex_n;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit kp(input int i, input int d, input int s);
    if (d >= s) return 1'b1;
    return ((i + 1) * d) / s != (i * d) / s;
  endfunction

  function automatic bit kl(input int ln, input int yd, input int ys, input int byp, input int scl);
    if (ln < byp) return 1'b1;
    if (ln < scl) return 1'b0;
    return kp(ln - scl, yd, ys);
  endfunction

  task automatic program_cfg(input int xd, xs, yd, ys, byp, scl);
    cfg_xd = 10'(xd); cfg_xs = 10'(xs); cfg_yd = 10'(yd);
    cfg_ys = 10'(ys); cfg_byp_lines = 10'(byp); cfg_scl_start = 10'(scl);
  endtask

  task automatic do_vsync();
    in_vsync = 1'b1;
    @(negedge clk);
    chk(vreset == 1'b1, "R11 pulse", 32'(vreset), 32'd1);
    in_vsync = 1'b0;
    @(negedge clk);
    chk(vreset == 1'b0, "R11 one cycle", 32'(vreset), 32'd0);
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < ex_n; k++) begin
      chk(!out_empty && rd_data == ex_q[k], req, rd_data, ex_q[k]);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
    end
    chk(out_empty == 1'b1, {req, " empty after drain"}, 32'(out_empty), 32'd1);
    ex_n = 0;
  endtask

  task automatic send_line(input int tag, ln, np, xd, xs, yd, ys, byp, scl, input string req);
    bit lk;
    lk = kl(ln, yd, ys, byp, scl);
    ex_n = 0;
    in_href = 1'b1;
    for (int p = 0; p < np; p++) begin
      in_valid = 1'b1;
      in_data  = {8'(tag), 8'(ln), 8'(p), 8'h5A};
      if (lk && (ln < byp || kp(p, xd, xs))) begin
        ex_q[ex_n] = in_data;
        ex_n++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_href  = 1'b0;
    @(negedge clk);
    chk(line_inc == lk, "R10 line_inc", 32'(line_inc), 32'(lk));
    drain(req);
  endtask

  // keep-all line without draining; expected words appended up to 16
  task automatic raw_line(input int tag, input int np);
    in_href = 1'b1;
    for (int p = 0; p < np; p++) begin
      in_valid = 1'b1;
      in_data  = {8'(tag), 8'hEE, 8'(p), 8'hC3};
      if (ex_n < 16) begin
        ex_q[ex_n] = in_data;
        ex_n++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_href  = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_href = 1'b0; in_vsync = 1'b0;
    rd_en = 1'b0; in_data = '0; ex_n = 0;
    program_cfg(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_empty == 1'b1, "R12 empty", 32'(out_empty), 32'd1);
    chk(out_half == 1'b0, "R12 half", 32'(out_half), 32'd0);
    chk(out_ovf == 1'b0, "R12 ovf", 32'(out_ovf), 32'd0);
    chk(line_inc == 1'b0, "R12 line_inc", 32'(line_inc), 32'd0);
    chk(vreset == 1'b0, "R12 vreset", 32'(vreset), 32'd0);

    for (int v = 0; v < 5; v++) begin
      program_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
      do_vsync();
      for (int l = 0; l < VEC[v][7]; l++) begin
        string lbl;
        if (l < VEC[v][4])                               lbl = "R3 bypass line";
        else if (l < VEC[v][5])                          lbl = "R4 gap line";
        else if (VEC[v][0] >= VEC[v][1] || VEC[v][2] >= VEC[v][3] || VEC[v][0] == 0)
                                                         lbl = "R5 ratio limit";
        else                                             lbl = "R1 R2 scaled line";
        send_line(v, l, VEC[v][6], VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3],
                  VEC[v][4], VEC[v][5], lbl);
      end
    end

    // R6: mid-field change is held off until the next field
    program_cfg(1, 2, 1, 1, 0, 0);
    do_vsync();
    program_cfg(1, 1, 1, 1, 0, 0);
    send_line(9, 0, 6, 1, 2, 1, 1, 0, 0, "R6 old params in field");
    do_vsync();
    send_line(10, 0, 6, 1, 1, 1, 1, 0, 0, "R6 new params after vsync");

    // R7: half flag threshold and order
    ex_n = 0;
    raw_line(11, 7);
    chk(!out_empty && !out_half, "R7 seven words not half", 32'(out_half), 32'd0);
    raw_line(12, 1);
    chk(out_half == 1'b1, "R7 eight words half", 32'(out_half), 32'd1);
    drain("R7 order");

    // R8: overflow drops extra words, sticky
    chk(out_ovf == 1'b0, "R8 no ovf yet", 32'(out_ovf), 32'd0);
    raw_line(13, 20);
    chk(out_ovf == 1'b1, "R8 ovf set", 32'(out_ovf), 32'd1);
    drain("R8 kept words intact");
    chk(out_ovf == 1'b1, "R8 ovf sticky", 32'(out_ovf), 32'd1);

    // R9: read on empty is ignored
    rd_en = 1'b1;
    repeat (3) @(negedge clk);
    rd_en = 1'b0;
    chk(out_empty == 1'b1, "R9 still empty", 32'(out_empty), 32'd1);
    raw_line(14, 2);
    drain("R9 data after empty read");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all R) actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule